// File: doc/BRIEF.md
# Debug Link Protocol Switch Sequencer

This block moves a dual-protocol serial debug link out of its two-wire mode and into the four-wire scan mode. It is built in one of two roles, picked by a parameter. In the generator role it emits the switch stream on the mode/data line. The stream is a long run of high bits, then a 16-bit select word sent least significant bit first, then a second long run of high bits. The generator presents one bit per bit-enable strobe and reports its progress with `busy` and a one-cycle `done` pulse. At the end the scan port's state machine is left in its reset state.

In the detector role the same block sits on the target side. It samples the line on each strobe and raises `jtag_mode` once it has seen enough leading high bits, an exact select word and a short trailing run of high bits. A second select word, the older deprecated one, can be accepted through a configuration input. Any mismatch sends the detector back to searching.

Top module: `link_mode_switch`

## Requirements
- R1: After reset, `line_out` is high, `busy` and `done` are low, and `jtag_mode` is low.
- R2: Starting from a `start` pulse while idle, the generator presents 56 high bits, each held until it is consumed on a clock edge with `bit_en` high.
- R3: The next 16 bits are the select word 0xE73C, least significant bit first, so byte 0x3C goes out before byte 0xE7.
- R4: The generator then presents 56 more high bits, 128 bits in total. On the edge that consumes the 128th bit, `busy` falls and `done` is high for exactly one cycle.
- R5: If `legacy_sel` is high when `start` is accepted, the select word is 0xDEAE instead (byte 0xAE first, then 0xDE, each LSB first).
- R6: While busy, a cycle with `bit_en` low leaves `line_out` and the bit position unchanged.
- R7: While busy, `start` and changes of `legacy_sel` have no effect on the stream being sent.
- R8: The detector raises `jtag_mode` right after it samples the 5th high bit that follows a complete select word, which itself must follow at least 50 consecutive high bits. Once high, `jtag_mode` stays high until reset.
- R9: Fewer than 50 high bits before the select word never lead to detection.
- R10: A sampled bit that differs from the select word restarts the search, and a later full sequence is still detected without a reset.
- R11: The detector accepts the word 0xDEAE only when `legacy_sel` is high at the first pattern bit. It always accepts 0xE73C.
- R12: A low bit among the trailing high bits restarts the search.
- R13: The detector takes a sample only on cycles with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe: consume (generator) or sample (detector) one bit |
| start | input | 1 | Generator: begin a switch stream when idle |
| legacy_sel | input | 1 | Generator: send the deprecated word; detector: also accept it |
| line_in | input | 1 | Detector: sampled mode/data line |
| line_out | output | 1 | Generator: mode/data line, high when idle |
| busy | output | 1 | Generator: stream in progress |
| done | output | 1 | Generator: one-cycle pulse when the last bit is consumed |
| jtag_mode | output | 1 | Detector: switch sequence recognised (sticky) |

## Verification
The generator is run with a continuous strobe, with a strobe that is high only every third cycle, with the deprecated word, and with `start` and `legacy_sel` toggled mid-stream. Each bit is compared with the stream expected for that position, so these runs separate a wrong word, a wrong bit order, a wrong run length, a failure to hold while stalled and a restart while busy. The detector is fed a clean stream, a stream with 49 leading ones, a stream with one flipped pattern bit, a stream with a low bit in the trailing run, and the deprecated word with and without its enable. It is also checked one sample before and one sample after the detection edge, and across a stalled strobe. Finally, the generator's line is looped into the detector to show that the two roles agree.

// File: rtl/lms_pkg.sv
package lms_pkg;
   localparam int             DEF_PAT_W   = 16;
   localparam logic [15:0]    DEF_PAT_NEW = 16'hE73C;
   localparam logic [15:0]    DEF_PAT_OLD = 16'hDEAE;

   typedef enum logic [1:0] {
      DS_HUNT,
      DS_PAT,
      DS_TAIL,
      DS_LOCK
   } det_state_e;
endpackage

// File: rtl/lms_gen.sv
module lms_gen #(
   parameter int                LEAD_ONES = 56,
   parameter int                TAIL_ONES = 56,
   parameter int                PAT_W     = 16,
   parameter logic [PAT_W-1:0]  PAT_NEW   = 16'hE73C,
   parameter logic [PAT_W-1:0]  PAT_OLD   = 16'hDEAE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic start,
   input  logic legacy_sel,
   output logic line_out,
   output logic busy,
   output logic done
);
   localparam int TOTAL = LEAD_ONES + PAT_W + TAIL_ONES;
   localparam int CW    = $clog2(TOTAL);
   localparam int PW    = $clog2(PAT_W);

   logic [CW-1:0]    idx_q;
   logic [PAT_W-1:0] pat_q;
   logic [CW-1:0]    off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         idx_q <= '0;
         pat_q <= PAT_NEW;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               idx_q <= '0;
               pat_q <= legacy_sel ? PAT_OLD : PAT_NEW;
            end
         end else if (bit_en) begin
            if (idx_q == CW'(TOTAL - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign off = idx_q - CW'(LEAD_ONES);

   always_comb begin
      if (!busy)
         line_out = 1'b1;
      else if (idx_q < CW'(LEAD_ONES))
         line_out = 1'b1;
      else if (idx_q < CW'(LEAD_ONES + PAT_W))
         line_out = pat_q[off[PW-1:0]];
      else
         line_out = 1'b1;
   end
endmodule

// File: rtl/lms_det.sv
module lms_det
   import lms_pkg::*;
#(
   parameter int                MIN_LEAD = 50,
   parameter int                MIN_TAIL = 5,
   parameter int                PAT_W    = 16,
   parameter logic [PAT_W-1:0]  PAT_NEW  = 16'hE73C,
   parameter logic [PAT_W-1:0]  PAT_OLD  = 16'hDEAE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic legacy_en,
   input  logic line_in,
   output logic jtag_mode
);
   localparam int OW = $clog2(MIN_LEAD + 1);
   localparam int TW = $clog2(MIN_TAIL + 1);
   localparam int PW = $clog2(PAT_W);

   det_state_e    st_q;
   logic [OW-1:0] ones_q;
   logic [TW-1:0] tail_q;
   logic [PW-1:0] pos_q;
   logic          ok_new_q, ok_old_q;
   logic          hit_new, hit_old;

   assign hit_new = ok_new_q && (line_in == PAT_NEW[pos_q]);
   assign hit_old = ok_old_q && (line_in == PAT_OLD[pos_q]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= DS_HUNT;
         ones_q   <= '0;
         tail_q   <= '0;
         pos_q    <= '0;
         ok_new_q <= 1'b0;
         ok_old_q <= 1'b0;
      end else if (bit_en) begin
         unique case (st_q)
            DS_HUNT: begin
               if (line_in) begin
                  if (ones_q != OW'(MIN_LEAD)) ones_q <= ones_q + 1'b1;
               end else begin
                  ones_q <= '0;
                  if (ones_q == OW'(MIN_LEAD)) begin
                     st_q     <= DS_PAT;
                     pos_q    <= PW'(1);
                     ok_new_q <= 1'b1;
                     ok_old_q <= legacy_en;
                  end
               end
            end
            DS_PAT: begin
               if (!(hit_new || hit_old)) begin
                  st_q   <= DS_HUNT;
                  ones_q <= line_in ? OW'(1) : '0;
               end else begin
                  ok_new_q <= hit_new;
                  ok_old_q <= hit_old;
                  if (pos_q == PW'(PAT_W - 1)) begin
                     st_q   <= DS_TAIL;
                     tail_q <= '0;
                  end else begin
                     pos_q <= pos_q + 1'b1;
                  end
               end
            end
            DS_TAIL: begin
               if (!line_in) begin
                  st_q   <= DS_HUNT;
                  ones_q <= '0;
               end else if (tail_q == TW'(MIN_TAIL - 1)) begin
                  st_q <= DS_LOCK;
               end else begin
                  tail_q <= tail_q + 1'b1;
               end
            end
            DS_LOCK: st_q <= DS_LOCK;
            default: st_q <= DS_HUNT;
         endcase
      end
   end

   assign jtag_mode = (st_q == DS_LOCK);
endmodule

// File: rtl/link_mode_switch.sv
module link_mode_switch
   import lms_pkg::*;
#(
   parameter bit                DETECTOR  = 1'b0,
   parameter int                LEAD_ONES = 56,
   parameter int                TAIL_ONES = 56,
   parameter int                MIN_LEAD  = 50,
   parameter int                MIN_TAIL  = 5,
   parameter int                PAT_W     = DEF_PAT_W,
   parameter logic [PAT_W-1:0]  PAT_NEW   = DEF_PAT_NEW,
   parameter logic [PAT_W-1:0]  PAT_OLD   = DEF_PAT_OLD
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic start,
   input  logic legacy_sel,
   input  logic line_in,
   output logic line_out,
   output logic busy,
   output logic done,
   output logic jtag_mode
);
   if (LEAD_ONES < MIN_LEAD) begin : g_bad_lead
      $error("LEAD_ONES must be at least MIN_LEAD");
   end
   if (TAIL_ONES < MIN_TAIL || MIN_TAIL < 1) begin : g_bad_tail
      $error("TAIL_ONES must be at least MIN_TAIL, which must be positive");
   end
   if (PAT_NEW[0] != 1'b0 || PAT_OLD[0] != 1'b0) begin : g_bad_pat
      $error("select words must begin with a low bit");
   end
   if (PAT_W < 2 || (PAT_W & (PAT_W - 1)) != 0) begin : g_bad_w
      $error("PAT_W must be a power of two");
   end

   if (DETECTOR) begin : g_det
      logic unused_gen_in;
      assign unused_gen_in = start;
      assign line_out = 1'b1;
      assign busy     = 1'b0;
      assign done     = 1'b0;
      lms_det #(
         .MIN_LEAD (MIN_LEAD),
         .MIN_TAIL (MIN_TAIL),
         .PAT_W    (PAT_W),
         .PAT_NEW  (PAT_NEW),
         .PAT_OLD  (PAT_OLD)
      ) u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .bit_en    (bit_en),
         .legacy_en (legacy_sel),
         .line_in   (line_in),
         .jtag_mode (jtag_mode)
      );
   end else begin : g_gen
      logic unused_det_in;
      assign unused_det_in = line_in;
      assign jtag_mode = 1'b0;
      lms_gen #(
         .LEAD_ONES (LEAD_ONES),
         .TAIL_ONES (TAIL_ONES),
         .PAT_W     (PAT_W),
         .PAT_NEW   (PAT_NEW),
         .PAT_OLD   (PAT_OLD)
      ) u_gen (
         .clk        (clk),
         .rst_n      (rst_n),
         .bit_en     (bit_en),
         .start      (start),
         .legacy_sel (legacy_sel),
         .line_out   (line_out),
         .busy       (busy),
         .done       (done)
      );
   end
endmodule

// File: rtl/link_mode_switch_chk.sv
module link_mode_switch_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic line_out,
   input logic busy,
   input logic done,
   input logic jtag_mode
);
   // R1: the line idles high whenever no stream is in flight
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line_out);

   // R4: done lasts a single cycle
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: done coincides with the end of busy
   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R6: a stalled strobe holds the presented bit
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_en) |=> $stable(line_out));

   // R8: detection is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      jtag_mode |=> jtag_mode);

   // R13: detection can only appear on a sampled cycle
   a_r13_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !jtag_mode) |=> !jtag_mode);
endmodule

bind link_mode_switch link_mode_switch_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .line_out  (line_out),
   .busy      (busy),
   .done      (done),
   .jtag_mode (jtag_mode)
);

// File: tb/link_mode_switch_bench.sv
`timescale 1ns/1ps
module link_mode_switch_bench;
   localparam int TOT = 128;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // generator side
   logic g_rst_n = 1'b0, g_en = 1'b0, g_start = 1'b0, g_legacy = 1'b0;
   logic g_line, g_busy, g_done, g_jm;
   // detector side
   logic d_rst_n = 1'b0, d_en_r = 1'b0, d_line_r = 1'b1, d_legacy = 1'b0;
   logic chain = 1'b0;
   logic d_en, d_line, d_lo, d_busy, d_done, d_jm;

   assign d_en   = chain ? g_en   : d_en_r;
   assign d_line = chain ? g_line : d_line_r;

   link_mode_switch #(.DETECTOR(1'b0)) u_link_mode_switch (
      .clk(clk), .rst_n(g_rst_n), .bit_en(g_en), .start(g_start),
      .legacy_sel(g_legacy), .line_in(1'b1), .line_out(g_line),
      .busy(g_busy), .done(g_done), .jtag_mode(g_jm));

   link_mode_switch #(.DETECTOR(1'b1)) u_link_mode_switch_rx (
      .clk(clk), .rst_n(d_rst_n), .bit_en(d_en), .start(1'b0),
      .legacy_sel(d_legacy), .line_in(d_line), .line_out(d_lo),
      .busy(d_busy), .done(d_done), .jtag_mode(d_jm));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(int k, logic leg);
      logic [15:0] w;
      w = leg ? 16'hDEAE : 16'hE73C;
      if (k < 56 || k >= 72) return 1'b1;
      return w[k - 56];
   endfunction

   // R1: reset values
   task automatic t_reset;
      @(negedge clk);
      chk("R1 line_out", g_line, 1);
      chk("R1 busy", g_busy, 0);
      chk("R1 done", g_done, 0);
      chk("R1 jtag_mode", d_jm, 0);
   endtask

   // R2 R3 R4 R5 R6 R7: one generator run, bit by bit
   task automatic run_gen(logic leg, bit gap, bit poke);
      int k = 0;
      int cyc = 0;
      string tag;
      @(negedge clk); g_legacy = leg; g_start = 1'b1; g_en = 1'b0;
      @(negedge clk); g_start = 1'b0;
      chk("R4 busy after start", g_busy, 1);
      while (k < TOT) begin
         g_en = gap ? (cyc % 3 == 0) : 1'b1;
         if (poke && k == 60) begin g_start = 1'b1; g_legacy = !leg; end
         else begin g_start = 1'b0; g_legacy = leg; end
         #1;
         if (k < 56) tag = "R2 lead bit";
         else if (k < 72) tag = leg ? "R5 legacy word bit" : "R3 word bit";
         else tag = "R4 tail bit";
         if (!g_en) tag = "R6 stalled bit";
         if (poke && k >= 60) tag = "R7 bit after mid-run poke";
         chk(tag, g_line, exp_bit(k, leg));
         @(posedge clk);
         if (g_en) k++;
         cyc++;
         @(negedge clk);
      end
      g_en = 1'b0; g_start = 1'b0;
      chk("R4 done after 128 bits", g_done, 1);
      chk("R4 busy low at end", g_busy, 0);
      @(negedge clk);
      chk("R4 done single cycle", g_done, 0);
   endtask

   task automatic d_reset;
      @(negedge clk); d_rst_n = 1'b0; d_en_r = 1'b0;
      @(negedge clk); d_rst_n = 1'b1;
   endtask

   task automatic d_bit(logic b);
      @(negedge clk); d_en_r = 1'b1; d_line_r = b;
      @(posedge clk);
   endtask

   task automatic d_ones(int n);
      for (int i = 0; i < n; i++) d_bit(1'b1);
   endtask

   task automatic d_word(logic [15:0] w);
      for (int i = 0; i < 16; i++) d_bit(w[i]);
   endtask

   task automatic d_check(string tag, logic exp);
      @(negedge clk); d_en_r = 1'b0;
      chk(tag, d_jm, exp);
   endtask

   // R8 R13: exact detection edge, stalled strobe, stickiness
   task automatic t_det_clean;
      d_reset(); d_legacy = 1'b0;
      d_ones(56); d_word(16'hE73C); d_ones(4);
      d_check("R8 not yet after 4 trailing ones", 0);
      d_line_r = 1'b1;
      repeat (5) @(negedge clk);
      chk("R13 no sample while strobe low", d_jm, 0);
      d_bit(1'b1);
      d_check("R8 set after 5th trailing one", 1);
      d_bit(1'b0); d_bit(1'b0);
      d_check("R8 sticky after zeros", 1);
   endtask

   // R9: short leading run
   task automatic t_det_short;
      d_reset();
      d_ones(49); d_word(16'hE73C); d_ones(10);
      d_check("R9 49 leading ones rejected", 0);
   endtask

   // R10: flipped pattern bit, then recovery
   task automatic t_det_mismatch;
      d_reset();
      d_ones(56); d_word(16'hE73C ^ 16'h0020); d_ones(10);
      d_check("R10 corrupted word rejected", 0);
      d_ones(56); d_word(16'hE73C); d_ones(5);
      d_check("R10 later sequence detected", 1);
   endtask

   // R11: deprecated word needs its enable
   task automatic t_det_legacy;
      d_reset(); d_legacy = 1'b0;
      d_ones(56); d_word(16'hDEAE); d_ones(8);
      d_check("R11 legacy word without enable", 0);
      d_reset(); d_legacy = 1'b1;
      d_ones(56); d_word(16'hDEAE); d_ones(5);
      d_check("R11 legacy word with enable", 1);
      d_legacy = 1'b0;
   endtask

   // R12: low bit inside trailing run
   task automatic t_det_tail_break;
      d_reset();
      d_ones(56); d_word(16'hE73C); d_ones(3); d_bit(1'b0); d_ones(5);
      d_check("R12 broken trailing run", 0);
   endtask

   // R8 R11: generator looped into detector, legacy accept enabled
   task automatic t_chain;
      d_reset(); d_legacy = 1'b1; chain = 1'b1;
      run_gen(1'b0, 1'b0, 1'b0);
      chain = 1'b0;
      chk("R8 looped stream detected", d_jm, 1);
      d_legacy = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      g_rst_n = 1'b1; d_rst_n = 1'b1;
      t_reset();
      run_gen(1'b0, 1'b0, 1'b0);
      run_gen(1'b1, 1'b0, 1'b0);
      run_gen(1'b0, 1'b1, 1'b0);
      run_gen(1'b0, 1'b0, 1'b1);
      t_det_clean();
      t_det_short();
      t_det_mismatch();
      t_det_legacy();
      t_det_tail_break();
      t_chain();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule